// File: doc/BRIEF.md
# Triggered Conversion Scheduler with Interrupt Flags

This block schedules the work of an analog-to-digital converter. It has sixteen conversion slots. Each slot holds an input channel number, an acquisition length and the choice of event that starts it. A slot can be started by one of four external trigger lines, or by a pulse from one of the first two interrupt flags. The second choice lets the end of one conversion start the next, so chains and loops of conversions run with no outside help.

When one or more slots are waiting, the scheduler serves the lowest-numbered one. It raises `sample_en` and drives the slot's channel on `chan_sel` for the acquisition length. It then waits a fixed conversion latency and captures `adc_data` into that slot's result register. Last, it pulses `eoc` and reports the slot number. A slot can post its end of conversion to one of four interrupt flags. Each flag has a continuous-mode bit. Without that bit, a post to a flag that is already raised gives no new pulse and sets the flag's overflow bit instead.

Software configures the block through a write port and a combinational read port. The converter itself sits outside the block, and its result arrives as a plain input bus.

Top module: `conv_sched`

## Requirements
- R1: After reset, no slot is pending and all flags and overflow bits are zero. `sample_en` and `eoc` are low, and every slot configuration word reads zero, which means its start source is "none".
- R2: A granted slot holds `sample_en` high for exactly the acquisition count in bits [7:0] of its configuration word. A count of 0 is treated as 1. During that time `chan_sel` equals bits [11:8] of the word.
- R3: `eoc` goes high for a single cycle, exactly 12 cycles after the first cycle in which `sample_en` is low again. In that cycle `eoc_slot` names the slot. The slot's result register (address 16 + slot) holds the `adc_data` value that was present during the conversion.
- R4: Bits [14:12] of a configuration word select the start source. 0 means none, 1 to 4 select `trig_in[0]` to `trig_in[3]`, 5 selects a pulse of flag 0 and 6 selects a pulse of flag 1. 7 also means none. A slot whose source is none never converts.
- R5: When several slots are pending in the same cycle, they are served in order of rising slot number.
- R6: Further start events for a slot that is already pending merge into that one request, so the slot converts once.
- R7: When bit 15 of a slot's configuration word is set, its end of conversion posts to the flag chosen by bits [17:16]. That flag then reads 1 in status bits [3:0] at address 33, and `irq_pulse` of that flag is high together with `eoc`.
- R8: When the flag's continuous bit is clear and the flag is already raised, a post gives no pulse and sets that flag's overflow bit (status bits [7:4]).
- R9: When the flag's continuous bit is set (address 32, bit per flag), every post gives a pulse and the overflow bit stays clear.
- R10: Writing a 1 to bit f of address 33 clears flag f and its overflow bit.
- R11: A pulse on flag 0 or flag 1 starts every slot whose source selects that flag, so one conversion can start the next.
- R12: Configuration words at addresses 0 to 15 read back as written over all 18 bits. Addresses 16 to 31 return the result registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 18 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 18 | Read data (combinational) |
| trig_in | input | 4 | External start events, one cycle high per event |
| sample_en | output | 1 | High during the acquisition window |
| chan_sel | output | 4 | Channel of the slot being converted |
| adc_data | input | 12 | Converter result bus |
| eoc | output | 1 | End-of-conversion pulse |
| eoc_slot | output | 4 | Slot that ended, valid with `eoc` |
| irq_pulse | output | 4 | One-cycle interrupt pulse per flag |
| irq_flag | output | 4 | Interrupt flag levels |

## Verification
The assertions check on every cycle that `eoc` lasts a single cycle and never overlaps acquisition, and that the channel stays stable through a window. They also check that an interrupt pulse always comes with its flag raised, and that overflow never rises in the same cycle as a pulse. The scenarios are the only place that can show several things: the exact window and latency counts, the captured result, the grant order of pending slots, and the merging of repeated triggers. The same holds for the fact that an unacknowledged flag in non-continuous mode breaks a chain of conversions.

// File: rtl/conv_sched_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the conversion scheduler.
// Assumes four interrupt flags, of which the two lowest may start slots.
package conv_sched_pkg;
    localparam int NFLAG   = 4;
    localparam int FSEL_W  = 2;
    localparam int NCHAIN  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_CONV
    } eng_state_t;
endpackage

// File: rtl/cs_regs.sv
`timescale 1ns/1ps
// Register file: slot configuration words, per-slot results, continuous-mode
// bits, and the read mux. The address's top two bits choose the region.
// A write of 1s to the status address makes a one-cycle acknowledge mask.
// Assumes NSLOT is a power of two.
module cs_regs
    import conv_sched_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int DATA_W = 12,
    parameter int REG_W  = 18,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              res_we,
    input  logic [$clog2(NSLOT)-1:0] res_idx,
    input  logic [DATA_W-1:0] res_data,
    input  logic [NFLAG-1:0]  irq_flag,
    input  logic [NFLAG-1:0]  irq_ovf,
    output logic [REG_W-1:0]  cfg_q [NSLOT],
    output logic [NFLAG-1:0]  cont_q,
    output logic [NFLAG-1:0]  ack
);
    localparam int IDX_W = $clog2(NSLOT);

    logic [DATA_W-1:0] res_q [NSLOT];
    logic [1:0]        wr_rgn, rd_rgn;
    logic [IDX_W-1:0]  wr_idx, rd_idx;

    assign wr_rgn = wr_addr[ADDR_W-1 -: 2];
    assign rd_rgn = rd_addr[ADDR_W-1 -: 2];
    assign wr_idx = wr_addr[IDX_W-1:0];
    assign rd_idx = rd_addr[IDX_W-1:0];

    // Slot configuration storage, cleared to "no source" at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) cfg_q[i] <= '0;
        end else if (wr_en && wr_rgn == 2'd0) begin
            cfg_q[wr_idx] <= wr_data;
        end
    end

    // Result capture from the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) res_q[i] <= '0;
        end else if (res_we) begin
            res_q[res_idx] <= res_data;
        end
    end

    // Continuous-mode bits, one per flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cont_q <= '0;
        else if (wr_en && wr_rgn == 2'd2 && wr_idx == IDX_W'(0))
            cont_q <= wr_data[NFLAG-1:0];
    end

    // Acknowledge mask from a write to the status address.
    always_comb begin
        ack = '0;
        if (wr_en && wr_rgn == 2'd2 && wr_idx == IDX_W'(1))
            ack = wr_data[NFLAG-1:0];
    end

    // Read mux over the three regions.
    always_comb begin
        rd_data = '0;
        case (rd_rgn)
            2'd0: rd_data = cfg_q[rd_idx];
            2'd1: rd_data = REG_W'(res_q[rd_idx]);
            2'd2: begin
                if (rd_idx == IDX_W'(0))
                    rd_data = REG_W'(cont_q);
                else if (rd_idx == IDX_W'(1))
                    rd_data = REG_W'({irq_ovf, irq_flag});
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cs_arbiter.sv
`timescale 1ns/1ps
// Pending-request collector and fixed-priority picker. Each slot decodes its
// source select against the external lines and the chain flag pulses. Repeat
// events merge into a single pending bit. The lowest pending slot is granted
// while the engine is idle. A new event in the grant cycle stays pending.
module cs_arbiter
    import conv_sched_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int NTRIG  = 4,
    parameter int TSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTRIG-1:0]  trig_in,
    input  logic [NCHAIN-1:0] chain_evt,
    input  logic [TSEL_W-1:0] tsel [NSLOT],
    input  logic              ready,
    output logic              grant_vld,
    output logic [$clog2(NSLOT)-1:0] grant_idx
);
    localparam int IDX_W = $clog2(NSLOT);

    logic [NSLOT-1:0] pend_q, hit, grant_mask;
    logic             found;

    // Source decode per slot.
    for (genvar s = 0; s < NSLOT; s++) begin : g_hit
        always_comb begin
            hit[s] = 1'b0;
            for (int t = 0; t < NTRIG; t++)
                if (tsel[s] == TSEL_W'(t + 1)) hit[s] = trig_in[t];
            for (int c = 0; c < NCHAIN; c++)
                if (tsel[s] == TSEL_W'(NTRIG + 1 + c)) hit[s] = chain_evt[c];
        end
    end

    // Lowest-numbered pending slot wins.
    always_comb begin
        grant_idx = '0;
        found     = 1'b0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant_idx = IDX_W'(i);
                found     = 1'b1;
            end
        end
    end

    assign grant_vld  = found && ready;
    assign grant_mask = grant_vld ? (NSLOT'(1) << grant_idx) : '0;

    // Pending bits: drop the granted one, add new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~grant_mask) | hit;
    end
endmodule

// File: rtl/cs_engine.sv
`timescale 1ns/1ps
// Conversion engine: acquisition window, then a fixed latency, then result
// capture and an end-of-conversion pulse. Slot fields are latched at grant.
// An acquisition count of zero runs as one cycle. Assumes CONV_LAT >= 1.
module cs_engine
    import conv_sched_pkg::*;
#(
    parameter int NSLOT    = 16,
    parameter int ACQ_W    = 8,
    parameter int CH_W     = 4,
    parameter int DATA_W   = 12,
    parameter int CONV_LAT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_vld,
    input  logic [$clog2(NSLOT)-1:0] grant_idx,
    input  logic [ACQ_W-1:0]   g_acq,
    input  logic [CH_W-1:0]    g_chan,
    input  logic               g_post,
    input  logic [FSEL_W-1:0]  g_fsel,
    input  logic [DATA_W-1:0]  adc_data,
    output logic               ready,
    output logic               sample_en,
    output logic [CH_W-1:0]    chan_sel,
    output logic               res_we,
    output logic [$clog2(NSLOT)-1:0] res_idx,
    output logic [DATA_W-1:0]  res_data,
    output logic [NFLAG-1:0]   post_req,
    output logic               eoc,
    output logic [$clog2(NSLOT)-1:0] eoc_slot
);
    localparam int IDX_W = $clog2(NSLOT);
    localparam int LAT_W = $clog2(CONV_LAT + 1);
    localparam int CNT_W = (ACQ_W > LAT_W) ? ACQ_W : LAT_W;

    eng_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  cur_q;
    logic [CH_W-1:0]   chan_q;
    logic              post_q;
    logic [FSEL_W-1:0] fsel_q;

    // Sequencing of idle, acquisition and conversion phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            cur_q  <= '0;
            chan_q <= '0;
            post_q <= 1'b0;
            fsel_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (grant_vld) begin
                    st     <= ST_ACQ;
                    cnt    <= (g_acq == '0) ? CNT_W'(1) : CNT_W'(g_acq);
                    cur_q  <= grant_idx;
                    chan_q <= g_chan;
                    post_q <= g_post;
                    fsel_q <= g_fsel;
                end
                ST_ACQ: begin
                    if (cnt == CNT_W'(1)) begin
                        st  <= ST_CONV;
                        cnt <= CNT_W'(CONV_LAT);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_CONV: begin
                    if (cnt == CNT_W'(1)) st <= ST_IDLE;
                    else                  cnt <= cnt - CNT_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ready     = (st == ST_IDLE);
    assign sample_en = (st == ST_ACQ);
    assign chan_sel  = chan_q;
    assign res_we    = (st == ST_CONV) && (cnt == CNT_W'(1));
    assign res_idx   = cur_q;
    assign res_data  = adc_data;
    assign post_req  = (res_we && post_q) ? (NFLAG'(1) << fsel_q) : '0;

    // End-of-conversion pulse and slot tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc      <= 1'b0;
            eoc_slot <= '0;
        end else begin
            eoc <= res_we;
            if (res_we) eoc_slot <= cur_q;
        end
    end
endmodule

// File: rtl/cs_irq.sv
`timescale 1ns/1ps
// Interrupt flags. A post raises its flag. It pulses when the flag is in
// continuous mode, when the flag was clear, or when the flag is being
// acknowledged in that cycle. Otherwise it sets the overflow bit. An
// acknowledge clears the flag and overflow unless a post comes in the same cycle.
module cs_irq
    import conv_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] post_req,
    input  logic [NFLAG-1:0] cont,
    input  logic [NFLAG-1:0] ack,
    output logic [NFLAG-1:0] irq_pulse,
    output logic [NFLAG-1:0] irq_flag,
    output logic [NFLAG-1:0] irq_ovf
);
    logic [NFLAG-1:0] fire;

    assign fire = post_req & (cont | ~irq_flag | ack);

    // Flag, overflow and pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag  <= '0;
            irq_ovf   <= '0;
            irq_pulse <= '0;
        end else begin
            irq_flag  <= (irq_flag & ~ack) | post_req;
            irq_ovf   <= (irq_ovf & ~ack) | (post_req & irq_flag & ~cont & ~ack);
            irq_pulse <= fire;
        end
    end
endmodule

// File: rtl/conv_sched.sv
`timescale 1ns/1ps
// Top of the conversion scheduler. Connects the register file, the pending
// arbiter, the conversion engine and the interrupt flags. Configuration word
// layout from bit 0: acquisition count, channel, source select, post enable,
// flag select.
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int NSLOT    = 16,
    parameter int ACQ_W    = 8,
    parameter int CH_W     = 4,
    parameter int DATA_W   = 12,
    parameter int NTRIG    = 4,
    parameter int CONV_LAT = 12,
    localparam int IDX_W   = $clog2(NSLOT),
    localparam int TSEL_W  = $clog2(NTRIG + NCHAIN + 1),
    localparam int REG_W   = ACQ_W + CH_W + TSEL_W + 1 + FSEL_W,
    localparam int ADDR_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NTRIG-1:0]  trig_in,
    output logic              sample_en,
    output logic [CH_W-1:0]   chan_sel,
    input  logic [DATA_W-1:0] adc_data,
    output logic              eoc,
    output logic [IDX_W-1:0]  eoc_slot,
    output logic [NFLAG-1:0]  irq_pulse,
    output logic [NFLAG-1:0]  irq_flag
);
    localparam int CH_LO = ACQ_W;
    localparam int TS_LO = CH_LO + CH_W;
    localparam int PE_B  = TS_LO + TSEL_W;
    localparam int FS_LO = PE_B + 1;

    logic [REG_W-1:0]  cfg_q [NSLOT];
    logic [TSEL_W-1:0] tsel  [NSLOT];
    logic [REG_W-1:0]  g_cfg;
    logic [NFLAG-1:0]  cont_q, ack, post_req, irq_ovf;
    logic              ready, grant_vld, res_we;
    logic [IDX_W-1:0]  grant_idx, res_idx;
    logic [DATA_W-1:0] res_data;

    cs_regs #(.NSLOT(NSLOT), .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .res_we(res_we), .res_idx(res_idx),
        .res_data(res_data), .irq_flag(irq_flag), .irq_ovf(irq_ovf),
        .cfg_q(cfg_q), .cont_q(cont_q), .ack(ack)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_tsel
        assign tsel[s] = cfg_q[s][TS_LO +: TSEL_W];
    end

    cs_arbiter #(.NSLOT(NSLOT), .NTRIG(NTRIG), .TSEL_W(TSEL_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .chain_evt(irq_pulse[NCHAIN-1:0]),
        .tsel(tsel), .ready(ready), .grant_vld(grant_vld), .grant_idx(grant_idx)
    );

    assign g_cfg = cfg_q[grant_idx];

    cs_engine #(.NSLOT(NSLOT), .ACQ_W(ACQ_W), .CH_W(CH_W), .DATA_W(DATA_W),
                .CONV_LAT(CONV_LAT)) u_eng (
        .clk(clk), .rst_n(rst_n), .grant_vld(grant_vld), .grant_idx(grant_idx),
        .g_acq(g_cfg[ACQ_W-1:0]), .g_chan(g_cfg[CH_LO +: CH_W]), .g_post(g_cfg[PE_B]),
        .g_fsel(g_cfg[FS_LO +: FSEL_W]), .adc_data(adc_data), .ready(ready),
        .sample_en(sample_en), .chan_sel(chan_sel), .res_we(res_we), .res_idx(res_idx),
        .res_data(res_data), .post_req(post_req), .eoc(eoc), .eoc_slot(eoc_slot)
    );

    cs_irq u_irq (
        .clk(clk), .rst_n(rst_n), .post_req(post_req), .cont(cont_q), .ack(ack),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag), .irq_ovf(irq_ovf)
    );
endmodule

// File: rtl/conv_sched_chk.sv
`timescale 1ns/1ps
// Property checker for the conversion scheduler, bound to the top module.
// Watches the converter handshake outputs and the interrupt flag state.
module conv_sched_chk #(
    parameter int CH_W  = 4,
    parameter int NFLAG = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_en,
    input logic [CH_W-1:0]  chan_sel,
    input logic             eoc,
    input logic [NFLAG-1:0] irq_pulse,
    input logic [NFLAG-1:0] irq_flag,
    input logic [NFLAG-1:0] irq_ovf
);
    // R3
    eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    // R3
    eoc_outside_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> !sample_en);

    // R2
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && $past(sample_en)) |-> $stable(chan_sel));

    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        // R7
        pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pulse[f] |-> irq_flag[f]);

        // R8
        ovf_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_ovf[f] |-> irq_flag[f]);

        // R8
        ovf_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_ovf[f]) |-> !irq_pulse[f]);
    end
endmodule

bind conv_sched conv_sched_chk #(.CH_W(CH_W), .NFLAG(conv_sched_pkg::NFLAG)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .chan_sel(chan_sel), .eoc(eoc),
    .irq_pulse(irq_pulse), .irq_flag(irq_flag), .irq_ovf(irq_ovf)
);

// File: tb/conv_sched_bench.sv
`timescale 1ns/1ps
module conv_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [17:0] rd_data;
    logic [3:0]  trig_in = '0;
    logic        sample_en;
    logic [3:0]  chan_sel;
    logic [11:0] adc_data = '0;
    logic        eoc;
    logic [3:0]  eoc_slot;
    logic [3:0]  irq_pulse;
    logic [3:0]  irq_flag;

    int nchk = 0;
    int nfail = 0;

    conv_sched u_conv_sched (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .trig_in(trig_in), .sample_en(sample_en),
        .chan_sel(chan_sel), .adc_data(adc_data), .eoc(eoc), .eoc_slot(eoc_slot),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag)
    );

    always #4 clk = ~clk;

    function automatic logic [17:0] mk_cfg(int acq, int chan, int tsel, int post, int fsel);
        return {2'(fsel), 1'(post), 3'(tsel), 4'(chan), 8'(acq)};
    endfunction

    function automatic int exp_win(int acq);
        return (acq == 0) ? 1 : acq;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [17:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int addr, output logic [17:0] data);
        rd_addr = 6'(addr);
        #1;
        data = rd_data;
    endtask

    task automatic pulse_trig(logic [3:0] m);
        @(negedge clk);
        trig_in = m;
        @(negedge clk);
        trig_in = '0;
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < 16; i++) wr(i, '0);
    endtask

    // Follows one conversion: window length, channel, latency, slot, pulses.
    task automatic observe(output int slot, output int win, output int lat,
                           output int chan, output logic [3:0] pls, output bit ok);
        int t = 0;
        ok = 1'b0; slot = -1; win = 0; lat = 0; chan = -1; pls = '0;
        while (!sample_en && t < 500) begin @(negedge clk); t++; end
        if (t >= 500) return;
        chan = int'(chan_sel);
        while (sample_en && win < 400) begin win++; @(negedge clk); end
        while (!eoc && lat < 100) begin lat++; @(negedge clk); end
        if (!eoc) return;
        slot = int'(eoc_slot);
        pls  = irq_pulse;
        ok   = 1'b1;
        @(negedge clk);
    endtask

    task automatic no_conv(int cycles, string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sample_en || eoc) seen++;
        end
        chk(seen == 0, req, "cycles with activity", seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [17:0] d;
        int s, w, l, c;
        logic [3:0] p;
        bit ok;

        seed = $urandom(32'h1c3a7);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sample_en == 1'b0 && eoc == 1'b0, "R1", "sample_en|eoc in reset", int'(sample_en | eoc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_flag == 4'b0, "R1", "flags after reset", int'(irq_flag), 0);
        rd(33, d);
        chk(d == '0, "R1", "status after reset", int'(d), 0);
        begin
            int nz = 0;
            for (int i = 0; i < 16; i++) begin rd(i, d); if (d != '0) nz++; end
            chk(nz == 0, "R1", "nonzero config words", nz, 0);
        end
        trig_in = 4'hF;
        @(negedge clk);
        trig_in = 4'h0;
        no_conv(30, "R1");

        // R12: random register readback
        begin
            logic [17:0] shadow [16];
            int bad = 0;
            for (int i = 0; i < 16; i++) begin
                shadow[i] = 18'($urandom) & ~18'h07000;
                wr(i, shadow[i]);
            end
            for (int i = 0; i < 16; i++) begin rd(i, d); if (d != shadow[i]) bad++; end
            chk(bad == 0, "R12", "mismatched readbacks", bad, 0);
            clear_cfg();
        end

        // R2/R3: random conversions
        for (int n = 0; n < 10; n++) begin
            int sl = $urandom_range(0, 15);
            int acq = $urandom_range(1, 25);
            int ch = $urandom_range(0, 15);
            int k = $urandom_range(0, 3);
            logic [11:0] dat = 12'($urandom);
            wr(sl, mk_cfg(acq, ch, k + 1, 0, 0));
            adc_data = dat;
            pulse_trig(4'(1 << k));
            observe(s, w, l, c, p, ok);
            chk(ok, "R2", "conversion seen", int'(ok), 1);
            chk(w == exp_win(acq), "R2", "window length", w, exp_win(acq));
            chk(c == ch, "R2", "channel", c, ch);
            chk(l == 12, "R3", "latency", l, 12);
            chk(s == sl, "R3", "eoc slot", s, sl);
            rd(16 + sl, d);
            chk(d == 18'(dat), "R3", "result", int'(d), int'(dat));
            wr(sl, '0);
        end

        // R2: zero acquisition count runs one cycle
        wr(7, mk_cfg(0, 9, 2, 0, 0));
        pulse_trig(4'b0010);
        observe(s, w, l, c, p, ok);
        chk(w == 1, "R2", "zero-count window", w, 1);
        wr(7, '0);

        // R4: sources 0 and 7 never start
        wr(3, mk_cfg(4, 1, 0, 0, 0));
        wr(4, mk_cfg(4, 1, 7, 0, 0));
        pulse_trig(4'hF);
        no_conv(40, "R4");
        clear_cfg();

        // R5: lowest slot first
        wr(9, mk_cfg(3, 2, 1, 0, 0));
        wr(3, mk_cfg(3, 5, 1, 0, 0));
        pulse_trig(4'b0001);
        observe(s, w, l, c, p, ok);
        chk(s == 3, "R5", "first slot", s, 3);
        observe(s, w, l, c, p, ok);
        chk(s == 9, "R5", "second slot", s, 9);
        clear_cfg();

        // R6: repeated triggers merge
        begin
            int n0 = 0, n2 = 0;
            wr(0, mk_cfg(30, 0, 1, 0, 0));
            wr(2, mk_cfg(2, 0, 2, 0, 0));
            pulse_trig(4'b0001);
            repeat (3) @(negedge clk);
            pulse_trig(4'b0010);
            repeat (2) @(negedge clk);
            pulse_trig(4'b0010);
            for (int i = 0; i < 150; i++) begin
                @(negedge clk);
                if (eoc && eoc_slot == 4'd0) n0++;
                if (eoc && eoc_slot == 4'd2) n2++;
            end
            chk(n0 == 1, "R6", "slot 0 conversions", n0, 1);
            chk(n2 == 1, "R6", "slot 2 conversions", n2, 1);
            clear_cfg();
        end

        // R7/R8/R10: posting to flag 2 in non-continuous mode
        wr(5, mk_cfg(2, 3, 3, 1, 2));
        pulse_trig(4'b0100);
        observe(s, w, l, c, p, ok);
        chk(p == 4'b0100, "R7", "pulse at eoc", int'(p), 4);
        rd(33, d);
        chk(d == 18'h004, "R7", "status after post", int'(d), 4);
        pulse_trig(4'b0100);
        observe(s, w, l, c, p, ok);
        chk(p == 4'b0000, "R8", "pulse while flag raised", int'(p), 0);
        rd(33, d);
        chk(d == 18'h044, "R8", "status overflow", int'(d), 'h44);
        wr(33, 18'h004);
        rd(33, d);
        chk(d == '0, "R10", "status after ack", int'(d), 0);
        chk(irq_flag == 4'b0, "R10", "flag pins after ack", int'(irq_flag), 0);

        // R9: continuous mode pulses every time
        wr(32, 18'h004);
        for (int i = 0; i < 2; i++) begin
            pulse_trig(4'b0100);
            observe(s, w, l, c, p, ok);
            chk(p == 4'b0100, "R9", "continuous pulse", int'(p), 4);
        end
        rd(33, d);
        chk(d == 18'h004, "R9", "status no overflow", int'(d), 4);
        wr(33, 18'h004);
        wr(32, 18'h000);
        clear_cfg();

        // R11: flag 0 chains slot 1 into slot 4
        wr(1, mk_cfg(3, 6, 1, 1, 0));
        wr(4, mk_cfg(5, 8, 5, 0, 0));
        pulse_trig(4'b0001);
        observe(s, w, l, c, p, ok);
        chk(s == 1 && p == 4'b0001, "R11", "first link slot", s, 1);
        observe(s, w, l, c, p, ok);
        chk(ok && s == 4, "R11", "chained slot", s, 4);
        chk(c == 8, "R11", "chained channel", c, 8);
        pulse_trig(4'b0001);
        observe(s, w, l, c, p, ok);
        chk(p == 4'b0000, "R8", "no pulse, flag 0 unacknowledged", int'(p), 0);
        no_conv(60, "R11");
        rd(33, d);
        chk(d == 18'h011, "R8", "flag 0 overflow", int'(d), 'h11);
        wr(33, 18'h001);
        rd(33, d);
        chk(d == '0, "R10", "flag 0 ack", int'(d), 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule